// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block runs read and write cycles on an external asynchronous static RAM that is organised as 128K words of 16 bits. The RAM has two active-low chip enables, one per byte lane, plus active-low write and output enables. A host hands the controller one request at a time over a request/ready handshake. Each request carries a word address, write data, a two-bit lane mask and a read/write flag. Read words come back with a one-cycle valid strobe.

All memory timing is set in whole clock cycles through parameters: strobe length for reads, write pulse width, write recovery and bus turnaround. The controller holds the address and write data steady for the whole access. It keeps output enable high while it writes. It turns its own data driver on only after the RAM's output enable has been high for at least one cycle. Lane mask bit 1 selects bits 15..8 through the upper chip enable, and bit 0 selects bits 7..0 through the lower chip enable.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready_o` is 1, both chip enables, `mem_we_no` and `mem_oe_no` are 1, `mem_dq_oe_o` is 0 and `rvalid_o` is 0.
- R2: A read with a nonzero mask holds `mem_oe_no` low for exactly RD_CYC cycles, keeps `mem_we_no` high, and drives `mem_ceu_no` low exactly when mask bit 1 is set and `mem_cel_no` low exactly when mask bit 0 is set.
- R3: After each read, `rvalid_o` pulses for one cycle. `rdata_o` holds the RAM word for the enabled lanes and 0 in every lane the mask left off.
- R4: A write with a nonzero mask holds `mem_we_no` low for exactly WR_PULSE cycles, together with the chip enables chosen by the mask, and `mem_oe_no` stays high during it.
- R5: `mem_dq_oe_o` is 1 only in cycles where `mem_oe_no` is high and was high the cycle before. Write data stays stable from before the strobes fall until at least one cycle after they rise.
- R6: After a write ends, the strobes stay high for at least WR_RECOV+1 cycles before the next access begins.
- R7: After a read's output enable rises, at least TURN+1 cycles pass before `mem_dq_oe_o` rises.
- R8: A request with mask 00 is accepted at once and drives no strobes. A write of this kind changes nothing in the RAM. A read of this kind returns `rvalid_o` on the next cycle with `rdata_o` = 0.
- R9: While any chip enable is low, `mem_addr_o` stays stable and equals the request's address.
- R10: `ready_o` is 0 from the cycle after a nonzero-mask request is accepted until the access has finished. Requests presented while `ready_o` is 0 are ignored.
- R11: A single-lane write leaves the other byte lane of that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| ready_o | output | 1 | Controller idle; a request is taken when req_i and ready_o are both high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane mask: bit 1 = bits 15..8, bit 0 = bits 7..0 |
| rdata_o | output | 16 | Read word; lanes not enabled are 0 |
| rvalid_o | output | 1 | One-cycle strobe marking rdata_o valid |
| mem_addr_o | output | 17 | RAM address |
| mem_ceu_no | output | 1 | Upper-lane chip enable, active low |
| mem_cel_no | output | 1 | Lower-lane chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 16 | Data driven to the RAM |
| mem_dq_i | input | 16 | Data read from the RAM |
| mem_dq_oe_o | output | 1 | Tristate enable for mem_dq_o |

## Verification
Some properties are checked by assertions on every cycle:
- output enable stays high whenever write enable is low;
- the data driver is never on while output enable is low, or in the first cycle after it rises;
- no write strobe appears without a chip enable;
- all strobes are quiet whenever the controller reports ready;
- the address and the write data do not move while an access holds them.

Other properties depend on counting cycles across a whole transaction, and only the bench scenarios show them:
- exact strobe widths, recovery gaps and turnaround gaps;
- zeroing of lanes that were not enabled;
- lane-preserving writes;
- requests dropped while the controller is busy;
- mask-00 requests that leave the RAM untouched.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctrl_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_CYC   = 10,
  parameter int unsigned WR_PULSE = 8,
  parameter int unsigned WR_RECOV = 1,
  parameter int unsigned TURN     = 1,
  parameter int unsigned LANES    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             zero_rd_o,
  output logic             capture_o,
  output logic [LANES-1:0] lanes_o,
  output logic [LANES-1:0] ce_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);

  localparam int unsigned MAXD = max2(max2(RD_CYC, WR_PULSE), max2(WR_RECOV, TURN));
  localparam int unsigned CW   = (MAXD < 2) ? 1 : $clog2(MAXD + 1);

  ctrl_state_e      state_q, state_d;
  logic [LANES-1:0] lanes_q, lanes_d;
  logic             tmr_load, tmr_zero;
  logic [CW-1:0]    tmr_val;
  logic             lane_act_d;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o & req_i;
  assign zero_rd_o = accept_o & ~we_i & ~(|be_i);
  assign capture_o = (state_q == ST_RD_CAPTURE);
  assign lanes_o   = lanes_q;
  assign lanes_d   = accept_o ? be_i : lanes_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (accept_o && (|be_i)) state_d = we_i ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (tmr_zero) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_TURNAROUND;
      ST_TURNAROUND: if (tmr_zero) state_d = ST_IDLE;
      ST_WR_SETUP:   state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (tmr_zero) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (tmr_zero) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // dwell loaded on state entry: read access leaves one cycle for capture
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_RD_ACCESS:  tmr_val = CW'(RD_CYC - 2);
      ST_WR_PULSE:   tmr_val = CW'(WR_PULSE - 1);
      ST_WR_RECOVER: tmr_val = CW'(WR_RECOV - 1);
      ST_TURNAROUND: tmr_val = CW'(TURN - 1);
      default:       tmr_val = '0;
    endcase
  end

  sram_cyc_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign lane_act_d = (state_d == ST_RD_ACCESS) || (state_d == ST_RD_CAPTURE) ||
                      (state_d == ST_WR_PULSE);

  // strobes are registered from next state so the pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lanes_q <= '0;
      ce_n_o  <= '1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      lanes_q <= lanes_d;
      ce_n_o  <= ~({LANES{lane_act_d}} & lanes_d);
      we_n_o  <= ~(state_d == ST_WR_PULSE);
      oe_n_o  <= ~((state_d == ST_RD_ACCESS) || (state_d == ST_RD_CAPTURE));
      dq_oe_o <= (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                 (state_d == ST_WR_RECOVER);
    end
  end

  p_oe_high_in_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o);

  p_we_needs_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !(&ce_n_o));

  p_drv_after_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_n_o && $past(oe_n_o)));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((&ce_n_o) && we_n_o && oe_n_o));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned AW    = 17,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             zero_rd_i,
  input  logic             capture_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic [LANES-1:0] ce_n_i,
  input  logic             dq_oe_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_dq_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);

  localparam int unsigned LW = DW / LANES;

  logic [DW-1:0] cap_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cap_word[g*LW +: LW] = lanes_i[g] ? mem_dq_i[g*LW +: LW] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i | zero_rd_i;
      if (capture_i)      rdata_o <= cap_word;
      else if (zero_rd_i) rdata_o <= '0;
    end
  end

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&ce_n_i) && $past(!(&ce_n_i))) |-> $stable(mem_addr_o));

  p_wdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_i && $past(dq_oe_i)) |-> $stable(mem_dq_o));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int unsigned AW       = 17,
  parameter int unsigned DW       = 16,
  parameter int unsigned RD_CYC   = 10,
  parameter int unsigned WR_PULSE = 8,
  parameter int unsigned WR_RECOV = 1,
  parameter int unsigned TURN     = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ceu_no,
  output logic          mem_cel_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe_o
);

  localparam int unsigned LANES = 2;

  logic             accept, zero_rd, capture;
  logic [LANES-1:0] lanes, ce_n;

  sram_seq_fsm #(
    .RD_CYC   (RD_CYC),
    .WR_PULSE (WR_PULSE),
    .WR_RECOV (WR_RECOV),
    .TURN     (TURN),
    .LANES    (LANES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .be_i      (be_i),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .zero_rd_o (zero_rd),
    .capture_o (capture),
    .lanes_o   (lanes),
    .ce_n_o    (ce_n),
    .we_n_o    (mem_we_no),
    .oe_n_o    (mem_oe_no),
    .dq_oe_o   (mem_dq_oe_o)
  );

  sram_data_path #(
    .AW    (AW),
    .DW    (DW),
    .LANES (LANES)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .zero_rd_i  (zero_rd),
    .capture_i  (capture),
    .lanes_i    (lanes),
    .ce_n_i     (ce_n),
    .dq_oe_i    (mem_dq_oe_o),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assign mem_ceu_no = ce_n[1];
  assign mem_cel_no = ce_n[0];

endmodule

// File: tb/sram_model_stub.sv
module sram_model_stub #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 16,
  parameter int unsigned IB = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ceu_n_i,
  input  logic          cel_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic [DW-1:0] dq_i,
  input  logic          dq_oe_i,
  output logic [DW-1:0] dq_o,
  output int            clash_o
);

  logic [DW-1:0] mem [2**IB];
  logic [IB-1:0] idx;
  logic          rd_on;

  assign idx   = addr_i[IB-1:0];
  assign rd_on = we_n_i && !oe_n_i && !(ceu_n_i && cel_n_i);

  initial begin
    clash_o = 0;
    for (int i = 0; i < 2**IB; i++) mem[i] = 16'(i * 257) ^ 16'h3c5a;
  end

  // unselected lanes float to a visible junk pattern
  always_comb begin
    dq_o = 16'ha5a5;
    if (rd_on) begin
      if (!ceu_n_i) dq_o[15:8] = mem[idx][15:8];
      if (!cel_n_i) dq_o[7:0]  = mem[idx][7:0];
    end
  end

  always @(posedge clk_i) begin
    if (!we_n_i && dq_oe_i) begin
      if (!ceu_n_i) mem[idx][15:8] <= dq_i[15:8];
      if (!cel_n_i) mem[idx][7:0]  <= dq_i[7:0];
    end
    if (dq_oe_i && rd_on) clash_o <= clash_o + 1;
  end

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

  localparam int unsigned RD_CYC   = 10;
  localparam int unsigned WR_PULSE = 8;
  localparam int unsigned WR_RECOV = 1;
  localparam int unsigned TURN     = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready_o, rvalid_o;
  logic [15:0] rdata_o;
  logic [16:0] mem_addr;
  logic        ceu_n, cel_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_to_mem, dq_from_mem;
  int          clash;

  always #5 clk = ~clk;

  sram_lane_ctrl #(
    .RD_CYC(RD_CYC), .WR_PULSE(WR_PULSE), .WR_RECOV(WR_RECOV), .TURN(TURN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready_o), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(mem_addr), .mem_ceu_no(ceu_n), .mem_cel_no(cel_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_dq_o(dq_to_mem), .mem_dq_i(dq_from_mem), .mem_dq_oe_o(dq_oe)
  );

  sram_model_stub #(.AW(17), .DW(16), .IB(8)) u_mem (
    .clk_i(clk), .addr_i(mem_addr), .ceu_n_i(ceu_n), .cel_n_i(cel_n), .we_n_i(we_n),
    .oe_n_i(oe_n), .dq_i(dq_to_mem), .dq_oe_i(dq_oe), .dq_o(dq_from_mem), .clash_o(clash)
  );

  int n_tests = 0, n_fail = 0;
  logic [15:0] shadow [256];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [1:0]  exp_lanes = '0;
  logic [16:0] exp_addr = '0;
  logic [15:0] exp_wdata = '0;
  int          strobe_cycles = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, input string tag);
    logic [7:0]  ix;
    logic [15:0] e;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    ix = a[7:0];
    req = 1'b1; we = w; addr = a; wdata = d; be = m;
    exp_lanes = m; exp_addr = a; exp_wdata = d;
    if (w) begin
      if (m[1]) shadow[ix][15:8] = d[15:8];
      if (m[0]) shadow[ix][7:0]  = d[7:0];
    end else begin
      e = shadow[ix] & {{8{m[1]}}, {8{m[0]}}};
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || !ready_o) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor state
  logic prev_oe_n = 1'b1, prev_we_n = 1'b1;
  int   oe_cnt = 0, we_cnt = 0, turn_cnt = 0, gap_cnt = 0;
  bit   turn_arm = 0, gap_arm = 0, rd_bad = 0, rd_addr_bad = 0, wr_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!(ceu_n && cel_n)) strobe_cycles++;
      if (!oe_n) begin
        oe_cnt++;
        if (!we_n || ({ceu_n, cel_n} != ~exp_lanes)) rd_bad = 1;
        if (mem_addr != exp_addr) rd_addr_bad = 1;
      end
      if (!oe_n && !prev_oe_n && dq_oe) rd_bad = 1;
      if (prev_oe_n == 1'b0 && oe_n) begin
        check(oe_cnt == RD_CYC, "R2", "read strobe width", oe_cnt, RD_CYC);
        check(!rd_bad, "R2", "read strobe pattern", {ceu_n, cel_n}, ~exp_lanes);
        check(!rd_addr_bad, "R9", "address held during read", mem_addr, exp_addr);
        oe_cnt = 0; rd_bad = 0; rd_addr_bad = 0;
        turn_arm = 1; turn_cnt = 1;
      end else if (turn_arm) begin
        if (dq_oe) begin
          check(turn_cnt >= TURN + 1, "R7", "turnaround before drive", turn_cnt, TURN + 1);
          turn_arm = 0;
        end else if (!oe_n) turn_arm = 0;
        else turn_cnt++;
      end
      if (!we_n) begin
        we_cnt++;
        if (!oe_n || ({ceu_n, cel_n} != ~exp_lanes) || !dq_oe ||
            dq_to_mem != exp_wdata || mem_addr != exp_addr) wr_bad = 1;
      end
      if (prev_we_n == 1'b0 && we_n) begin
        check(we_cnt == WR_PULSE, "R4", "write pulse width", we_cnt, WR_PULSE);
        check(!wr_bad, "R4", "write strobes/oe/address/data", {ceu_n, cel_n}, ~exp_lanes);
        check(dq_oe && dq_to_mem == exp_wdata, "R5", "data hold after write",
              dq_to_mem, exp_wdata);
        we_cnt = 0; wr_bad = 0;
        gap_arm = 1; gap_cnt = 1;
      end else if (gap_arm) begin
        if (!(ceu_n && cel_n)) begin
          check(gap_cnt >= WR_RECOV + 1, "R6", "recovery gap", gap_cnt, WR_RECOV + 1);
          gap_arm = 0;
        end else gap_cnt++;
      end
      if (rvalid_o) begin
        if (exp_q.size() == 0) check(0, "R3", "unexpected rvalid", rdata_o, 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rdata_o === e, t, "read data", rdata_o, e);
        end
      end
      prev_oe_n = oe_n;
      prev_we_n = we_n;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sc;
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) shadow[i] = 16'(i * 257) ^ 16'h3c5a;

    repeat (3) @(negedge clk);
    check(ready_o && ceu_n && cel_n && we_n && oe_n && !dq_oe && !rvalid_o,
          "R1", "outputs in reset", {ready_o, ceu_n, cel_n, we_n, oe_n, dq_oe, rvalid_o}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o && ceu_n && cel_n && we_n && oe_n && !dq_oe && !rvalid_o,
          "R1", "outputs after reset", {ready_o, ceu_n, cel_n, we_n, oe_n, dq_oe, rvalid_o}, 7'b1111100);

    // reads, all mask patterns (R3 lane zeroing)
    issue(0, 17'd5, '0, 2'b11, "R3");
    issue(0, 17'd6, '0, 2'b10, "R3");
    issue(0, 17'd7, '0, 2'b01, "R3");
    drain();

    // full write and readback, then single-lane writes (R11)
    issue(1, 17'd10, 16'h1234, 2'b11, "R4");
    issue(0, 17'd10, '0, 2'b11, "R3");
    issue(1, 17'd11, 16'hbeef, 2'b10, "R11");
    issue(0, 17'd11, '0, 2'b11, "R11");
    issue(1, 17'd12, 16'hcafe, 2'b01, "R11");
    issue(0, 17'd12, '0, 2'b11, "R11");
    drain();

    // back-to-back writes (R6), write after read (R7)
    issue(1, 17'd20, 16'h0f0f, 2'b11, "R6");
    issue(1, 17'd21, 16'hf0f0, 2'b11, "R6");
    issue(0, 17'd20, '0, 2'b11, "R7");
    issue(1, 17'd22, 16'h5555, 2'b11, "R7");
    issue(0, 17'd21, '0, 2'b11, "R6");
    issue(0, 17'd22, '0, 2'b11, "R7");
    drain();

    // mask 00 requests (R8)
    sc = strobe_cycles;
    issue(1, 17'd13, 16'hffff, 2'b00, "R8");
    @(negedge clk);
    check(ready_o, "R8", "ready after zero-mask write", ready_o, 1);
    repeat (3) @(negedge clk);
    check(strobe_cycles == sc, "R8", "no strobes for zero mask", strobe_cycles, sc);
    issue(0, 17'd13, '0, 2'b00, "R8");
    issue(0, 17'd13, '0, 2'b11, "R8");
    drain();

    // busy-time requests ignored (R10)
    issue(0, 17'd30, '0, 2'b11, "R10");
    @(negedge clk);
    check(!ready_o, "R10", "ready low while busy", ready_o, 0);
    req = 1'b1; we = 1'b1; addr = 17'd30; wdata = 16'hdead; be = 2'b11;
    repeat (4) @(negedge clk);
    req = 1'b0;
    drain();
    issue(0, 17'd30, '0, 2'b11, "R10");
    drain();

    // high address aliasing onto a low stub word, still one word per address
    issue(1, 17'h1_0040, 16'h7e81, 2'b11, "R9");
    issue(0, 17'h1_0040, '0, 2'b11, "R9");
    drain();

    // mixed traffic
    lfsr = 16'hace1;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], {9'd0, lfsr[11:4]}, lfsr ^ 16'h9a3c, lfsr[3:2],
            lfsr[3:2] == 2'b00 ? "R8" : "R3");
    end
    drain();

    check(clash == 0, "R5", "bus contention cycles", clash, 0);
    check(exp_q.size() == 0, "R3", "outstanding reads", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule